// File: doc/BRIEF.md
# SPI opcode instruction decoder

This block is the serial front end of a peripheral controlled over SPI. Each transaction opens when chip select goes low. The first eight SCK rising edges shift in an opcode, most significant bit first. The opcode then fixes what happens next:

- a data field of 8, 16, 32 or 256 bits that is written into the device or read out of it;
- an open-ended run of 32-bit words for the transmit FIFO;
- no data at all, in which case a one-cycle action strobe fires as soon as the eighth bit lands, while chip select is still low.

All serial pins are brought into the system clock through a synchronizer with edge detection. Every internal strobe and data bus therefore lives in one clock domain.

On the internal side the block drives write strobes with their data buses for a 16-bit control register, an 8-bit clock-divide register, a transmit word FIFO and a 256-entry label table. It reads a status byte, the control and divide registers, the head of a receive word FIFO and single label bits. The storage behind those buses sits outside the block.

Top module: `spi_opcode_decoder`

## Requirements
- R1: The opcode is the eight SI bits sampled on the first eight SCK rising edges after chip select falls, MSB first. Opcodes 0x00, 0x09 and 0x0F, and any opcode above 0x12 (for example 0x13..0x1F, 0x40, 0x80, 0xFF), raise no strobe, and SO stays 0 for the rest of the frame.
- R2: Opcodes without data pulse one strobe after the eighth opcode bit, before chip select rises: 0x01 chip reset, 0x02 clear every label, 0x03 set every label, 0x11 transmit FIFO clear.
- R3: Opcode 0x12 pulses the transmit-start strobe only if control bit 13 (as seen on `ctrl_rdata_i`) is 0.
- R4: Opcode 0x10 takes the next 16 SI bits, MSB first, and pulses `ctrl_wr_o` once with that value on `ctrl_wdata_o`.
- R5: Opcode 0x07 takes 8 bits and pulses `div_wr_o` once with that value on `div_wdata_o`.
- R6: Opcodes 0x04 and 0x05 take an 8-bit label address and write 0 (0x04) or 1 (0x05) to that single label.
- R7: Opcode 0x06 takes 256 bits. The first bit goes to label 0xFF and each following bit to the next lower label, down to 0x00.
- R8: Opcode 0x0E pushes every complete 32-bit word, MSB first, into the transmit FIFO. At most 32 words are pushed per chip-select-low frame, and later words are dropped.
- R9: Opcodes 0x0A (status, 8 bits), 0x0B (control, 16 bits) and 0x0C (divide, 8 bits) return their value MSB first on SO. The MSB is set up at the SCK falling edge after the eighth opcode bit.
- R10: Opcode 0x08 returns the receive FIFO head word (32 bits) and pulses `rxf_pop_o` once. When the FIFO is empty it returns all zeros and does not pop.
- R11: Opcode 0x0D returns 256 label bits, starting at label 0xFF and descending.
- R12: Chip select rising at any point aborts the frame. A partly shifted data word raises no strobe, and the next frame starts with a fresh opcode.
- R13: While chip select is high the SO driver is disabled (`spi_so_oe_o` = 0, SO high-impedance or 0 by parameter). After a read field is exhausted, SO is 0.
- R14: Strobes last one system clock, and no two strobes are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| spi_cs_n_i | input | 1 | Chip select, active low |
| spi_sck_i | input | 1 | Serial clock |
| spi_si_i | input | 1 | Serial data in |
| spi_so_o | output | 1 | Serial data out |
| spi_so_oe_o | output | 1 | SO driver enable |
| ctrl_wr_o | output | 1 | Control register write strobe |
| ctrl_wdata_o | output | 16 | Control register write value |
| ctrl_rdata_i | input | 16 | Current control register value |
| stat_rdata_i | input | 8 | Status byte |
| div_wr_o | output | 1 | Divide register write strobe |
| div_wdata_o | output | 8 | Divide register write value |
| div_rdata_i | input | 8 | Current divide register value |
| rxf_pop_o | output | 1 | Receive FIFO pop strobe |
| rxf_rdata_i | input | 32 | Receive FIFO head word |
| rxf_empty_i | input | 1 | Receive FIFO empty |
| txf_push_o | output | 1 | Transmit FIFO push strobe |
| txf_wdata_o | output | 32 | Transmit FIFO push word |
| txf_clr_o | output | 1 | Transmit FIFO clear strobe |
| tx_go_o | output | 1 | Transmit start strobe |
| chip_reset_o | output | 1 | Chip-wide reset strobe |
| lbl_clr_all_o | output | 1 | Clear all labels strobe |
| lbl_set_all_o | output | 1 | Set all labels strobe |
| lbl_wr_o | output | 1 | Single label write strobe |
| lbl_waddr_o | output | 8 | Label write address |
| lbl_wbit_o | output | 1 | Label write value |
| lbl_raddr_o | output | 8 | Label read address |
| lbl_rbit_i | input | 1 | Label bit at `lbl_raddr_o` |

## Verification
The assertions take it for granted that SCK is slow against the system clock. Each SCK level must hold for more than the synchronizer depth plus one cycle, so every edge is seen exactly once. SI must be settled before the rising edge that samples it, and chip select may change only while SCK is low. The receive FIFO head word must be valid whenever `rxf_empty_i` is low. The bench holds each SCK level for eight system clocks and changes SI only together with a falling SCK. It moves chip select only with SCK low and long before the next edge. Its FIFO and register stubs update on the clock edge after each strobe.

// File: rtl/spi_opdec_pkg.sv
package spi_opdec_pkg;

    localparam int OP_W    = 8;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int LBL_AW  = 8;
    localparam int CNT_W   = 9;
    localparam int GATE_BIT = 13;

    typedef enum logic [2:0] {
        FLD_NONE, FLD_BYTE, FLD_HALF, FLD_WORD, FLD_TABLE, FLD_BURST
    } fld_e;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_RX, SRC_STAT, SRC_CTRL, SRC_DIV, SRC_LBL
    } src_e;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_LCLR1, TGT_LSET1, TGT_LTAB, TGT_DIV, TGT_CTRL, TGT_TXF
    } tgt_e;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_RESET, ACT_LCLR, ACT_LSET, ACT_TXCLR, ACT_TXGO
    } act_e;

    typedef struct packed {
        fld_e fld;
        src_e src;
        tgt_e tgt;
        act_e act;
    } opinfo_t;

    typedef enum logic [1:0] {PH_OP, PH_DATA, PH_DONE} phase_e;

    function automatic logic [CNT_W-1:0] fld_len(fld_e f);
        case (f)
            FLD_BYTE:  return CNT_W'(BYTE_W);
            FLD_HALF:  return CNT_W'(HALF_W);
            FLD_WORD:  return CNT_W'(WORD_W);
            FLD_BURST: return CNT_W'(WORD_W);
            FLD_TABLE: return CNT_W'(1 << LBL_AW);
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/spi_opdec_sync.sv
module spi_opdec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic si_i,
    output logic cs_act_o,
    output logic si_o,
    output logic sck_rise_o,
    output logic sck_fall_o
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] IDLE = 3'b100;

    logic [STAGES-1:0][NPIN-1:0] stg_d, stg_q;
    logic prev_d, prev_q;
    logic sck_s;

    generate
        if (STAGES == 1) begin : g_one
            always_comb stg_d = {cs_n_i, sck_i, si_i};
        end else begin : g_many
            always_comb stg_d = {stg_q[STAGES-2:0], {cs_n_i, sck_i, si_i}};
        end
    endgenerate

    assign sck_s  = stg_q[STAGES-1][1];
    always_comb prev_d = sck_s;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            stg_q  <= {STAGES{IDLE}};
            prev_q <= 1'b0;
        end else begin
            stg_q  <= stg_d;
            prev_q <= prev_d;
        end
    end

    assign cs_act_o   = ~stg_q[STAGES-1][2];
    assign si_o       = stg_q[STAGES-1][0];
    assign sck_rise_o = sck_s & ~prev_q;
    assign sck_fall_o = ~sck_s & prev_q;

    // R14
    edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sck_rise_o |=> !sck_rise_o);

endmodule

// File: rtl/spi_opdec_table.sv
module spi_opdec_table
    import spi_opdec_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output opinfo_t         info_o
);
    always_comb begin
        info_o = '{fld: FLD_NONE, src: SRC_NONE, tgt: TGT_NONE, act: ACT_NONE};
        case (op_i)
            8'h01: info_o.act = ACT_RESET;
            8'h02: info_o.act = ACT_LCLR;
            8'h03: info_o.act = ACT_LSET;
            8'h11: info_o.act = ACT_TXCLR;
            8'h12: info_o.act = ACT_TXGO;
            8'h04: begin info_o.fld = FLD_BYTE;  info_o.tgt = TGT_LCLR1; end
            8'h05: begin info_o.fld = FLD_BYTE;  info_o.tgt = TGT_LSET1; end
            8'h06: begin info_o.fld = FLD_TABLE; info_o.tgt = TGT_LTAB;  end
            8'h07: begin info_o.fld = FLD_BYTE;  info_o.tgt = TGT_DIV;   end
            8'h10: begin info_o.fld = FLD_HALF;  info_o.tgt = TGT_CTRL;  end
            8'h0E: begin info_o.fld = FLD_BURST; info_o.tgt = TGT_TXF;   end
            8'h08: begin info_o.fld = FLD_WORD;  info_o.src = SRC_RX;    end
            8'h0A: begin info_o.fld = FLD_BYTE;  info_o.src = SRC_STAT;  end
            8'h0B: begin info_o.fld = FLD_HALF;  info_o.src = SRC_CTRL;  end
            8'h0C: begin info_o.fld = FLD_BYTE;  info_o.src = SRC_DIV;   end
            8'h0D: begin info_o.fld = FLD_TABLE; info_o.src = SRC_LBL;   end
            default: ;
        endcase
    end

    // R1
    always_comb begin
        dec_shape_chk: assert ((info_o.fld == FLD_NONE) ==
                               (info_o.src == SRC_NONE && info_o.tgt == TGT_NONE));
    end

endmodule

// File: rtl/spi_opcode_decoder.sv
module spi_opcode_decoder
    import spi_opdec_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int TX_BURST_MAX = 32,
    parameter bit SO_HIZ       = 1'b1
) (
    input  logic        clk_i,
    input  logic        rst_n_i,
    input  logic        spi_cs_n_i,
    input  logic        spi_sck_i,
    input  logic        spi_si_i,
    output logic        spi_so_o,
    output logic        spi_so_oe_o,
    output logic        ctrl_wr_o,
    output logic [15:0] ctrl_wdata_o,
    input  logic [15:0] ctrl_rdata_i,
    input  logic [7:0]  stat_rdata_i,
    output logic        div_wr_o,
    output logic [7:0]  div_wdata_o,
    input  logic [7:0]  div_rdata_i,
    output logic        rxf_pop_o,
    input  logic [31:0] rxf_rdata_i,
    input  logic        rxf_empty_i,
    output logic        txf_push_o,
    output logic [31:0] txf_wdata_o,
    output logic        txf_clr_o,
    output logic        tx_go_o,
    output logic        chip_reset_o,
    output logic        lbl_clr_all_o,
    output logic        lbl_set_all_o,
    output logic        lbl_wr_o,
    output logic [7:0]  lbl_waddr_o,
    output logic        lbl_wbit_o,
    output logic [7:0]  lbl_raddr_o,
    input  logic        lbl_rbit_i
);
    localparam int WC_W = $clog2(TX_BURST_MAX + 1);
    localparam logic [WC_W-1:0] WC_MAX = WC_W'(TX_BURST_MAX);
    localparam int PC_W = $clog2(TX_BURST_MAX + 2);

    typedef struct packed {
        phase_e              ph;
        logic [OP_W-1:0]     opsh;
        logic [3:0]          opn;
        opinfo_t             info;
        logic [CNT_W-1:0]    dbit;
        logic [WC_W-1:0]     wcnt;
        logic [WORD_W-1:0]   wsh;
        logic [WORD_W-1:0]   rsh;
        logic [LBL_AW-1:0]   ptr;
        logic                so;
        logic                mrst;
        logic                lclr;
        logic                lset;
        logic                txclr;
        logic                txgo;
        logic                cwr;
        logic                dwr;
        logic                push;
        logic                pop;
        logic                lwr;
        logic                lwb;
        logic [LBL_AW-1:0]   lwa;
    } st_t;

    st_t d, q;

    logic cs_act, si_s, sck_rise, sck_fall;
    logic [OP_W-1:0] nxt_op;
    logic [CNT_W-1:0] nbit;
    opinfo_t dec;

    spi_opdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .cs_n_i     (spi_cs_n_i),
        .sck_i      (spi_sck_i),
        .si_i       (spi_si_i),
        .cs_act_o   (cs_act),
        .si_o       (si_s),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall)
    );

    assign nxt_op = {q.opsh[OP_W-2:0], si_s};

    spi_opdec_table u_table (
        .op_i   (nxt_op),
        .info_o (dec)
    );

    always_comb begin
        d = q;
        nbit = q.dbit + CNT_W'(1);
        {d.mrst, d.lclr, d.lset, d.txclr, d.txgo, d.cwr, d.dwr, d.push, d.pop, d.lwr} = '0;
        if (!cs_act) begin
            d.ph   = PH_OP;
            d.opsh = '0;
            d.opn  = '0;
            d.dbit = '0;
            d.wcnt = '0;
            d.wsh  = '0;
            d.rsh  = '0;
            d.so   = 1'b0;
            d.info = '{fld: FLD_NONE, src: SRC_NONE, tgt: TGT_NONE, act: ACT_NONE};
        end else if (sck_rise) begin
            case (q.ph)
                PH_OP: begin
                    d.opsh = nxt_op;
                    d.opn  = q.opn + 4'd1;
                    if (q.opn == 4'(OP_W - 1)) begin
                        d.info = dec;
                        d.dbit = '0;
                        d.ptr  = '1;
                        d.ph   = (dec.fld == FLD_NONE) ? PH_DONE : PH_DATA;
                        case (dec.act)
                            ACT_RESET: d.mrst  = 1'b1;
                            ACT_LCLR:  d.lclr  = 1'b1;
                            ACT_LSET:  d.lset  = 1'b1;
                            ACT_TXCLR: d.txclr = 1'b1;
                            ACT_TXGO:  d.txgo  = ~ctrl_rdata_i[GATE_BIT];
                            default: ;
                        endcase
                        case (dec.src)
                            SRC_RX: begin
                                d.rsh = rxf_empty_i ? '0 : rxf_rdata_i;
                                d.pop = ~rxf_empty_i;
                            end
                            SRC_STAT: d.rsh = {stat_rdata_i, {(WORD_W-BYTE_W){1'b0}}};
                            SRC_CTRL: d.rsh = {ctrl_rdata_i, {(WORD_W-HALF_W){1'b0}}};
                            SRC_DIV:  d.rsh = {div_rdata_i, {(WORD_W-BYTE_W){1'b0}}};
                            default:  d.rsh = '0;
                        endcase
                    end
                end
                PH_DATA: begin
                    d.wsh  = {q.wsh[WORD_W-2:0], si_s};
                    d.dbit = nbit;
                    case (q.info.tgt)
                        TGT_LTAB: begin
                            d.lwr = 1'b1;
                            d.lwa = q.ptr;
                            d.lwb = si_s;
                            d.ptr = q.ptr - LBL_AW'(1);
                        end
                        TGT_LCLR1, TGT_LSET1: begin
                            if (nbit == CNT_W'(BYTE_W)) begin
                                d.lwr = 1'b1;
                                d.lwa = d.wsh[LBL_AW-1:0];
                                d.lwb = (q.info.tgt == TGT_LSET1);
                            end
                        end
                        TGT_DIV:  d.dwr = (nbit == CNT_W'(BYTE_W));
                        TGT_CTRL: d.cwr = (nbit == CNT_W'(HALF_W));
                        TGT_TXF: begin
                            if (nbit == CNT_W'(WORD_W)) begin
                                d.dbit = '0;
                                if (q.wcnt < WC_MAX) begin
                                    d.push = 1'b1;
                                    d.wcnt = q.wcnt + WC_W'(1);
                                end
                            end
                        end
                        default: ;
                    endcase
                    if (q.info.tgt != TGT_TXF && nbit == fld_len(q.info.fld)) begin
                        d.ph = PH_DONE;
                    end
                end
                default: ;
            endcase
        end else if (sck_fall) begin
            d.so = 1'b0;
            if (q.ph == PH_DATA) begin
                if (q.info.src == SRC_LBL) begin
                    d.so  = lbl_rbit_i;
                    d.ptr = q.ptr - LBL_AW'(1);
                end else if (q.info.src != SRC_NONE) begin
                    d.so  = q.rsh[WORD_W-1];
                    d.rsh = {q.rsh[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            q      <= '0;
            q.ph   <= PH_OP;
            q.ptr  <= '1;
        end else begin
            q <= d;
        end
    end

    assign ctrl_wr_o     = q.cwr;
    assign ctrl_wdata_o  = q.wsh[HALF_W-1:0];
    assign div_wr_o      = q.dwr;
    assign div_wdata_o   = q.wsh[BYTE_W-1:0];
    assign rxf_pop_o     = q.pop;
    assign txf_push_o    = q.push;
    assign txf_wdata_o   = q.wsh;
    assign txf_clr_o     = q.txclr;
    assign tx_go_o       = q.txgo;
    assign chip_reset_o  = q.mrst;
    assign lbl_clr_all_o = q.lclr;
    assign lbl_set_all_o = q.lset;
    assign lbl_wr_o      = q.lwr;
    assign lbl_waddr_o   = q.lwa;
    assign lbl_wbit_o    = q.lwb;
    assign lbl_raddr_o   = q.ptr;
    assign spi_so_oe_o   = cs_act;

    generate
        if (SO_HIZ) begin : g_hiz
            assign spi_so_o = cs_act ? q.so : 1'bz;
        end else begin : g_low
            assign spi_so_o = cs_act & q.so;
        end
    endgenerate

    logic [PC_W-1:0] chk_push_q;
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)        chk_push_q <= '0;
        else if (!cs_act)    chk_push_q <= '0;
        else if (txf_push_o) chk_push_q <= chk_push_q + PC_W'(1);
    end

    // R14
    strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0({chip_reset_o, lbl_clr_all_o, lbl_set_all_o, txf_clr_o, tx_go_o,
                  ctrl_wr_o, div_wr_o, txf_push_o, rxf_pop_o, lbl_wr_o}));

    // R3
    txgo_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        tx_go_o |-> !$past(ctrl_rdata_i[GATE_BIT]));

    // R10
    empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rxf_pop_o |-> !$past(rxf_empty_i));

    // R8
    burst_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        chk_push_q <= PC_W'(TX_BURST_MAX));

    // R12
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!cs_act && $past(!cs_act)) |-> !(ctrl_wr_o || div_wr_o || txf_push_o || lbl_wr_o));

endmodule

// File: tb/sim_spi_opcode_decoder.sv
module sim_spi_opcode_decoder;
    localparam int H = 8;
    localparam int BUFW = 1056;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic so, so_oe;
    logic ctrl_wr, div_wr, pop, push, txclr, go, mrst, lclr, lset, lwr, lwb;
    logic [15:0] ctrl_wdata;
    logic [15:0] ctrl_m = 16'h0;
    logic [7:0]  stat = 8'h0;
    logic [7:0]  div_wdata;
    logic [7:0]  div_m = 8'h0;
    logic [31:0] txd;
    logic [7:0]  lwa, lra;
    logic [255:0] lbl_m = '0;
    logic [31:0] rxq [4];
    int rx_wr = 0, rx_rd = 0;
    logic [31:0] txq [64];
    int txn = 0;
    int n_mrst = 0, n_go = 0, n_txclr = 0, n_pop = 0, n_cwr = 0, n_dwr = 0;
    int n_push = 0, n_lwr = 0, n_lclr = 0, n_lset = 0;
    int total = 0, bad = 0, sum_at_cs = 0;
    logic [BUFW-1:0] wbuf, rbuf;

    always #4 clk = ~clk;

    spi_opcode_decoder u0 (
        .clk_i(clk), .rst_n_i(rst_n),
        .spi_cs_n_i(cs_n), .spi_sck_i(sck), .spi_si_i(si),
        .spi_so_o(so), .spi_so_oe_o(so_oe),
        .ctrl_wr_o(ctrl_wr), .ctrl_wdata_o(ctrl_wdata), .ctrl_rdata_i(ctrl_m),
        .stat_rdata_i(stat),
        .div_wr_o(div_wr), .div_wdata_o(div_wdata), .div_rdata_i(div_m),
        .rxf_pop_o(pop), .rxf_rdata_i(rxq[rx_rd[1:0]]), .rxf_empty_i(rx_wr == rx_rd),
        .txf_push_o(push), .txf_wdata_o(txd), .txf_clr_o(txclr), .tx_go_o(go),
        .chip_reset_o(mrst), .lbl_clr_all_o(lclr), .lbl_set_all_o(lset),
        .lbl_wr_o(lwr), .lbl_waddr_o(lwa), .lbl_wbit_o(lwb),
        .lbl_raddr_o(lra), .lbl_rbit_i(lbl_m[lra])
    );

    always @(posedge clk) begin
        if (ctrl_wr) begin ctrl_m <= ctrl_wdata; n_cwr <= n_cwr + 1; end
        if (div_wr)  begin div_m <= div_wdata; n_dwr <= n_dwr + 1; end
        if (lclr)    begin lbl_m <= '0; n_lclr <= n_lclr + 1; end
        if (lset)    begin lbl_m <= '1; n_lset <= n_lset + 1; end
        if (lwr)     begin lbl_m[lwa] <= lwb; n_lwr <= n_lwr + 1; end
        if (push)    begin txq[txn[5:0]] <= txd; txn <= txn + 1; n_push <= n_push + 1; end
        if (txclr)   begin txn <= 0; n_txclr <= n_txclr + 1; end
        if (pop)     begin rx_rd <= rx_rd + 1; n_pop <= n_pop + 1; end
        if (go)      n_go <= n_go + 1;
        if (mrst)    n_mrst <= n_mrst + 1;
    end

    function automatic int strobes();
        return n_mrst + n_go + n_txclr + n_pop + n_cwr + n_dwr + n_push + n_lwr + n_lclr + n_lset;
    endfunction

    function automatic logic exp_lbl(int l);
        return ((l * 5 + 3) % 7) < 3;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic put(input int base, input logic [31:0] v, input int w);
        for (int k = 0; k < w; k++) wbuf[base + k] = v[w - 1 - k];
    endtask

    function automatic logic [31:0] get(input int base, input int w);
        logic [31:0] v = '0;
        for (int k = 0; k < w; k++) v = {v[30:0], rbuf[base + k]};
        return v;
    endfunction

    task automatic xfer(input logic [7:0] op, input int nd, input int cut);
        int tot;
        tot = 8 + nd;
        rbuf = '0;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < tot; i++) begin
            if (cut >= 0 && i == cut) break;
            sck = 1'b0;
            si = (i < 8) ? op[7 - i] : wbuf[i - 8];
            repeat (H) @(negedge clk);
            if (i >= 8) rbuf[i - 8] = so;
            sck = 1'b1;
            repeat (H) @(negedge clk);
        end
        sck = 1'b0;
        repeat (H) @(negedge clk);
        sum_at_cs = strobes();
        cs_n = 1'b1;
        repeat (3 * H) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s, mis;
        logic [7:0] idle_ops [0:17];
        logic [7:0] dvals [0:5];
        logic [7:0] svals [0:4];
        idle_ops = '{8'h00, 8'h09, 8'h0F, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17, 8'h18,
                     8'h19, 8'h1A, 8'h1B, 8'h1C, 8'h1D, 8'h1E, 8'h1F, 8'h80, 8'hFF};
        dvals = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h0A, 8'hA5};
        svals = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'h5A};
        wbuf = '0;
        rbuf = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R13 reset so_oe", so_oe, 0);
        chk("R14 reset strobes", strobes(), 0);

        stat = 8'hA5;
        wbuf = '0;
        foreach (idle_ops[j]) begin
            s = strobes();
            xfer(idle_ops[j], 8, -1);
            chk("R1 idle opcode strobes", strobes(), s);
            chk("R1 idle opcode SO", rbuf[7:0], 0);
        end

        s = n_mrst; xfer(8'h01, 0, -1);
        chk("R2 chip reset", n_mrst, s + 1);
        chk("R2 before cs rise", sum_at_cs, strobes());
        xfer(8'h03, 0, -1);
        chk("R2 set all labels", lbl_m == '1, 1);
        xfer(8'h02, 0, -1);
        chk("R2 clear all labels", lbl_m == '0, 1);
        s = n_txclr; xfer(8'h11, 0, -1);
        chk("R2 tx clear", n_txclr, s + 1);

        put(0, 32'h2000, 16); s = n_cwr; xfer(8'h10, 16, -1);
        chk("R4 ctrl write", ctrl_m, 16'h2000);
        chk("R14 one ctrl strobe", n_cwr, s + 1);
        s = n_go; xfer(8'h12, 0, -1);
        chk("R3 tx start blocked", n_go, s);
        put(0, 32'hDFFF, 16); xfer(8'h10, 16, -1);
        chk("R4 ctrl write", ctrl_m, 16'hDFFF);
        s = n_go; xfer(8'h12, 0, -1);
        chk("R3 tx start allowed", n_go, s + 1);
        wbuf = '0; xfer(8'h0B, 24, -1);
        chk("R9 ctrl read", get(0, 16), 16'hDFFF);
        chk("R13 trailing zero", get(16, 8), 0);

        foreach (dvals[j]) begin
            wbuf = '0; put(0, {24'h0, dvals[j]}, 8); xfer(8'h07, 8, -1);
            chk("R5 divide write", div_m, dvals[j]);
            wbuf = '0; xfer(8'h0C, 8, -1);
            chk("R9 divide read", get(0, 8), dvals[j]);
        end

        foreach (svals[j]) begin
            stat = svals[j];
            wbuf = '0; xfer(8'h0A, 16, -1);
            chk("R9 status read", get(0, 8), svals[j]);
            chk("R13 after field", get(8, 8), 0);
        end

        xfer(8'h03, 0, -1);
        wbuf = '0; put(0, 32'h37, 8); xfer(8'h04, 8, -1);
        chk("R6 clear one label", lbl_m[8'h37], 0);
        chk("R6 others kept", $countones(lbl_m), 255);
        wbuf = '0; put(0, 32'h37, 8); xfer(8'h05, 8, -1);
        chk("R6 set one label", lbl_m == '1, 1);
        wbuf = '0; put(0, 32'hFF, 8); xfer(8'h04, 8, -1);
        chk("R6 top label", lbl_m[255], 0);
        wbuf = '0; xfer(8'h04, 8, -1);
        chk("R6 bottom label", lbl_m[0], 0);
        chk("R6 count", $countones(lbl_m), 254);

        wbuf = '0;
        for (int i = 0; i < 256; i++) wbuf[i] = exp_lbl(255 - i);
        xfer(8'h06, 256, -1);
        mis = 0;
        for (int l = 0; l < 256; l++) if (lbl_m[l] !== exp_lbl(l)) mis++;
        chk("R7 table write descending", mis, 0);
        wbuf = '0; xfer(8'h0D, 256, -1);
        mis = 0;
        for (int i = 0; i < 256; i++) if (rbuf[i] !== exp_lbl(255 - i)) mis++;
        chk("R11 table read descending", mis, 0);

        rxq[0] = 32'hA1B2C3D4; rxq[1] = 32'h0F0F0F0F; rxq[2] = 32'h0; rxq[3] = 32'h0;
        rx_wr = 2;
        s = n_pop;
        wbuf = '0; xfer(8'h08, 32, -1);
        chk("R10 first word", get(0, 32), 32'hA1B2C3D4);
        xfer(8'h08, 32, -1);
        chk("R10 second word", get(0, 32), 32'h0F0F0F0F);
        rxq[2] = 32'hFFFFFFFF;
        xfer(8'h08, 32, -1);
        chk("R10 empty reads zero", get(0, 32), 0);
        chk("R10 pops", n_pop, s + 2);

        xfer(8'h11, 0, -1);
        wbuf = '0;
        for (int w = 0; w < 3; w++) put(w * 32, 32'h1000_0001 * (w + 3), 32);
        xfer(8'h0E, 96, -1);
        chk("R8 three words", txn, 3);
        chk("R8 word order", txq[2], 32'h1000_0001 * 5);
        xfer(8'h11, 0, -1);
        wbuf = '0;
        for (int w = 0; w < 33; w++) put(w * 32, 32'hC0DE_0000 + w, 32);
        xfer(8'h0E, 33 * 32, -1);
        chk("R8 burst limit", txn, 32);
        chk("R8 last kept", txq[31], 32'hC0DE_001F);
        chk("R8 first kept", txq[0], 32'hC0DE_0000);

        wbuf = '0; put(0, 32'h1111, 16); xfer(8'h10, 16, -1);
        s = n_cwr;
        wbuf = '0; put(0, 32'hFFFF, 16); xfer(8'h10, 16, 18);
        chk("R12 partial discarded", ctrl_m, 16'h1111);
        chk("R12 no strobe", n_cwr, s);
        s = n_mrst;
        xfer(8'h10, 0, 4);
        xfer(8'h01, 0, -1);
        chk("R12 fresh opcode", n_mrst, s + 1);
        chk("R13 idle so_oe", so_oe, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule